// File: doc/BRIEF.md
# Pipelined SPI ADC Scan Sequencer

This block is an SPI master that walks through the enabled channels of a 16-input serial converter. The converter answers each conversion command two words late. A start strobe latches a 16-bit channel-enable mask. The block then sends one 16-bit conversion command per enabled channel, lowest channel first. After the last command it sends two all-zero filler words, so that the last two results can still be clocked out.

Every word that comes back is tagged with the channel it belongs to. The sequencer drops the first two returned words of a scan, because they hold nothing from this scan. It lines up each later word with the command sent two frames before it, compares the tag against that command's channel, and takes out the sample at the configured resolution. It presents the sample with its channel number and a mismatch flag.

The SPI clock rate comes from a half-period divider input. The sample resolution is an elaboration parameter.

Top module: `adc_scan_seq`

## Requirements
- R1: Every word is 16 bits, sent MSB first in SPI mode 0. The SCLK idle level is low. MOSI changes only while SCLK is low, and MISO is sampled at the rising SCLK edge. Chip select goes low before each word and rises after it, and it stays high for at least one SCLK half period between words.
- R2: A conversion command word has bit 12 set, the channel number in bits 10:7, and every other bit zero.
- R3: Commands go out only for channels whose mask bit is 1, in ascending channel order.
- R4: After the last command, exactly two all-zero words follow, so a scan with K enabled channels is K+2 words long.
- R5: The words returned during the first two frames of a scan are dropped. The word returned during frame k+2 is delivered as sample k.
- R6: The delivered sample is bits [11 : 12-N] of the returned word, where N is SAMPLE_BITS (12, 10 or 8). The delivered channel is the channel of the matching command.
- R7: When bits 15:12 of a returned word differ from the expected channel, the sample is still delivered, with the error flag set. Otherwise the flag is clear.
- R8: busy rises in the cycle after an accepted start and falls in the same cycle as a one-cycle done pulse. That cycle also carries the last sample. A start pulse while busy has no effect on the words sent or the samples delivered.
- R9: A start with an all-zero mask sends no word, never raises busy, and pulses done in the cycle after the start.
- R10: Each SCLK high phase lasts half_div+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Scan start strobe |
| ch_mask_i | input | 16 | Channel enable mask, bit i enables channel i |
| half_div_i | input | 8 | SCLK half period minus one, in clock cycles |
| spi_sclk_o | output | 1 | SPI clock |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Command data to the converter |
| spi_miso_i | input | 1 | Result data from the converter |
| smp_valid_o | output | 1 | Sample valid pulse |
| smp_data_o | output | SAMPLE_BITS | Extracted sample |
| smp_chan_o | output | 4 | Channel of the sample |
| smp_err_o | output | 1 | Returned tag did not match the channel |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan complete pulse |

## Verification
The hardest case to reach from the ports is a result word whose tag disagrees with the command it answers. A well-behaved converter never produces one. The bench therefore plays the converter and deliberately corrupts the tag returned for one chosen channel. It then checks that this sample still arrives, in its place in the stream, with only its error flag set. A second hard case is a start strobe that lands in the middle of a long scan. The bench pulses start with a different mask about forty cycles into a scan and confirms that the command stream and sample stream both follow the original mask.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    localparam int FRAME_W      = 16;
    localparam int CMD_CONV_BIT = 12;
    localparam int CMD_CH_LSB   = 7;
    localparam int TAG_LSB      = 12;
    localparam int TAG_W        = 4;
    localparam int PAD_FRAMES   = 2;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_word_engine.sv
module spi_word_engine
    import adc_scan_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [WORD_W-1:0] tx_word_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    output logic              fin_o,
    output logic [WORD_W-1:0] rx_word_o
);

    localparam int BCNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        eng_state_e        st;
        logic [DIV_W-1:0]  div_cnt;
        logic [BCNT_W-1:0] bit_cnt;
        logic              sclk;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic              fin;
    } eng_t;

    eng_t eng_d, eng_q;
    logic tick;

    assign tick = (eng_q.div_cnt == half_div_i);

    always_comb begin
        eng_d     = eng_q;
        eng_d.fin = 1'b0;
        case (eng_q.st)
            ENG_IDLE: begin
                if (go_i) begin
                    eng_d.st      = ENG_SHIFT;
                    eng_d.tx      = tx_word_i;
                    eng_d.div_cnt = '0;
                    eng_d.bit_cnt = '0;
                    eng_d.sclk    = 1'b0;
                end
            end
            ENG_SHIFT: begin
                if (tick) begin
                    eng_d.div_cnt = '0;
                    if (!eng_q.sclk) begin
                        eng_d.sclk    = 1'b1;
                        eng_d.rx      = {eng_q.rx[WORD_W-2:0], miso_i};
                        eng_d.bit_cnt = eng_q.bit_cnt + 1'b1;
                    end else begin
                        eng_d.sclk = 1'b0;
                        if (eng_q.bit_cnt == BCNT_W'(WORD_W)) begin
                            eng_d.st = ENG_GAP;
                        end else begin
                            eng_d.tx = {eng_q.tx[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    eng_d.div_cnt = eng_q.div_cnt + 1'b1;
                end
            end
            ENG_GAP: begin
                if (tick) begin
                    eng_d.st      = ENG_IDLE;
                    eng_d.fin     = 1'b1;
                    eng_d.div_cnt = '0;
                end else begin
                    eng_d.div_cnt = eng_q.div_cnt + 1'b1;
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, div_cnt: '0, bit_cnt: '0, sclk: 1'b0,
                       tx: '0, rx: '0, fin: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sclk_o    = eng_q.sclk;
    assign cs_n_o    = (eng_q.st != ENG_SHIFT);
    assign mosi_o    = eng_q.tx[WORD_W-1];
    assign fin_o     = eng_q.fin;
    assign rx_word_o = eng_q.rx;

    // R1: clock toggles only inside a selected word
    assert_sclk_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    // R1: data out is held while the clock is high
    assert_mosi_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

    // R4: the sequencer launches a word only into an idle engine
    assert_go_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> (eng_q.st == ENG_IDLE));

endmodule

// File: rtl/chan_pick.sv
module chan_pick #(
    parameter int NCH  = 16,
    parameter int CH_W = 4
) (
    input  logic [NCH-1:0]  mask_i,
    output logic            any_o,
    output logic [CH_W-1:0] ch_o
);

    always_comb begin
        ch_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_i[i]) ch_o = CH_W'(i);
        end
    end

    assign any_o = |mask_i;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int SAMPLE_BITS = 12,
    parameter int DIV_W       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [NUM_CH-1:0]      ch_mask_i,
    input  logic [DIV_W-1:0]       half_div_i,
    output logic                   spi_sclk_o,
    output logic                   spi_cs_n_o,
    output logic                   spi_mosi_o,
    input  logic                   spi_miso_i,
    output logic                   smp_valid_o,
    output logic [SAMPLE_BITS-1:0] smp_data_o,
    output logic [TAG_W-1:0]       smp_chan_o,
    output logic                   smp_err_o,
    output logic                   busy_o,
    output logic                   done_o
);

    localparam int CH_W  = TAG_W;
    localparam int PAD_W = $clog2(PAD_FRAMES + 1);
    localparam int SMP_HI = TAG_LSB - 1;

    typedef struct packed {
        logic                   run;
        logic [NUM_CH-1:0]      rem;
        logic [PAD_W-1:0]       pad;
        logic                   inflight;
        logic                   cur_vld;
        logic [CH_W-1:0]        cur_ch;
        logic                   p0_vld;
        logic [CH_W-1:0]        p0_ch;
        logic                   p1_vld;
        logic [CH_W-1:0]        p1_ch;
        logic                   smp_vld;
        logic [SAMPLE_BITS-1:0] smp_data;
        logic [CH_W-1:0]        smp_ch;
        logic                   smp_err;
        logic                   done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                pick_any;
    logic [CH_W-1:0]     pick_ch;
    logic                go;
    logic [FRAME_W-1:0]  tx_word;
    logic                fin;
    logic [FRAME_W-1:0]  rx_word;

    chan_pick #(.NCH(NUM_CH), .CH_W(CH_W)) i_pick (
        .mask_i (seq_q.rem),
        .any_o  (pick_any),
        .ch_o   (pick_ch)
    );

    assign go = seq_q.run && !seq_q.inflight && (pick_any || (seq_q.pad != '0));

    always_comb begin
        tx_word = '0;
        if (pick_any) begin
            tx_word[CMD_CONV_BIT]                 = 1'b1;
            tx_word[CMD_CH_LSB +: CH_W]           = pick_ch;
        end
    end

    spi_word_engine #(.WORD_W(FRAME_W), .DIV_W(DIV_W)) i_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .tx_word_i  (tx_word),
        .half_div_i (half_div_i),
        .miso_i     (spi_miso_i),
        .sclk_o     (spi_sclk_o),
        .cs_n_o     (spi_cs_n_o),
        .mosi_o     (spi_mosi_o),
        .fin_o      (fin),
        .rx_word_o  (rx_word)
    );

    always_comb begin
        seq_d         = seq_q;
        seq_d.smp_vld = 1'b0;
        seq_d.done    = 1'b0;
        if (!seq_q.run) begin
            if (start_i) begin
                if (ch_mask_i == '0) begin
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.run      = 1'b1;
                    seq_d.rem      = ch_mask_i;
                    seq_d.pad      = PAD_W'(PAD_FRAMES);
                    seq_d.inflight = 1'b0;
                    seq_d.p0_vld   = 1'b0;
                    seq_d.p1_vld   = 1'b0;
                end
            end
        end else begin
            if (go) begin
                seq_d.inflight = 1'b1;
                seq_d.cur_vld  = pick_any;
                seq_d.cur_ch   = pick_ch;
                if (pick_any) seq_d.rem[pick_ch] = 1'b0;
                else          seq_d.pad = seq_q.pad - 1'b1;
            end
            if (fin) begin
                seq_d.inflight = 1'b0;
                if (seq_q.p1_vld) begin
                    seq_d.smp_vld  = 1'b1;
                    seq_d.smp_ch   = seq_q.p1_ch;
                    seq_d.smp_data = rx_word[SMP_HI -: SAMPLE_BITS];
                    seq_d.smp_err  = (rx_word[TAG_LSB +: TAG_W] != seq_q.p1_ch);
                end
                seq_d.p1_vld = seq_q.p0_vld;
                seq_d.p1_ch  = seq_q.p0_ch;
                seq_d.p0_vld = seq_q.cur_vld;
                seq_d.p0_ch  = seq_q.cur_ch;
                if (!pick_any && seq_q.pad == '0) begin
                    seq_d.run  = 1'b0;
                    seq_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign smp_valid_o = seq_q.smp_vld;
    assign smp_data_o  = seq_q.smp_data;
    assign smp_chan_o  = seq_q.smp_ch;
    assign smp_err_o   = seq_q.smp_err;
    assign busy_o      = seq_q.run;
    assign done_o      = seq_q.done;

    // R9: no word is selected outside a scan
    assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> spi_cs_n_o);

    // R8: busy only begins in response to a start strobe
    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R8: completion and busy never overlap
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5: samples only come out of a running scan
    assert_sample_in_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> $past(busy_o));

endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

    localparam int SB = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] ch_mask = '0;
    logic [7:0]  half_div = '0;
    logic        sclk, cs_n, mosi;
    logic        miso = 1'b0;
    logic        smp_valid, smp_err, busy, done;
    logic [SB-1:0] smp_data;
    logic [3:0]  smp_chan;

    always #2 clk = ~clk;

    adc_scan_seq #(.NUM_CH(16), .SAMPLE_BITS(SB), .DIV_W(8)) i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ch_mask_i(ch_mask),
        .half_div_i(half_div), .spi_sclk_o(sclk), .spi_cs_n_o(cs_n),
        .spi_mosi_o(mosi), .spi_miso_i(miso), .smp_valid_o(smp_valid),
        .smp_data_o(smp_data), .smp_chan_o(smp_chan), .smp_err_o(smp_err),
        .busy_o(busy), .done_o(done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int scan_id = 0;
    logic [15:0] cur_mask = '0;
    int corrupt_ch = -1;
    int frame_no = 0;
    int ch_hist [0:31];
    int exp_cmd_q [$];
    int exp_ch_q [$];
    int exp_dat_q [$];
    int exp_err_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int raw12(input int c);
        return (c * 311 + scan_id * 165 + 961) % 4096;
    endfunction

    function automatic logic [15:0] make_reply(input int j);
        int c, tag;
        if (j >= 2 && j < 32 && ch_hist[j-2] >= 0) begin
            c = ch_hist[j-2];
            tag = (c == corrupt_ch) ? (c ^ 5) : c;
            return {4'(tag), 12'(raw12(c))};
        end
        return 16'hEB3D;
    endfunction

    // converter model and per-clock comparison
    initial begin
        logic pcs, psclk;
        logic [15:0] rsh, tsh;
        int bitn, hi_cnt, gap_cnt, c;
        bit hi_done;
        pcs = 1'b1; psclk = 1'b0; rsh = '0; tsh = '0;
        bitn = 0; hi_cnt = 0; gap_cnt = 0; hi_done = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pcs && !cs_n) begin
                    if (frame_no > 0)
                        chk(gap_cnt >= int'(half_div) + 1, "R1 cs gap", gap_cnt, int'(half_div) + 1);
                    tsh = make_reply(frame_no);
                    miso = tsh[15];
                    bitn = 0; rsh = '0; hi_done = 0;
                end
                if (!cs_n) begin
                    if (!psclk && sclk) begin
                        rsh = {rsh[14:0], mosi};
                        bitn++;
                        hi_cnt = 0;
                    end
                    if (sclk) hi_cnt++;
                    if (psclk && !sclk) begin
                        if (!hi_done)
                            chk(hi_cnt == int'(half_div) + 1, "R10 sclk high", hi_cnt, int'(half_div) + 1);
                        hi_done = 1;
                        tsh = {tsh[14:0], 1'b0};
                        miso = tsh[15];
                    end
                end
                if (!pcs && cs_n) begin
                    chk(bitn == 16, "R1 bits per word", bitn, 16);
                    if (rsh[12]) begin
                        c = int'(rsh[10:7]);
                        if (exp_cmd_q.size() > 0) begin
                            chk(rsh == (16'h1000 | (16'(exp_cmd_q[0]) << 7)), "R2 R3 command",
                                int'(rsh), int'(16'h1000 | (16'(exp_cmd_q[0]) << 7)));
                            void'(exp_cmd_q.pop_front());
                        end else chk(0, "R3 extra command", int'(rsh), 0);
                    end else begin
                        c = -1;
                        chk(rsh == 16'h0 && exp_cmd_q.size() == 0, "R4 filler word", int'(rsh), 0);
                    end
                    if (frame_no < 32) ch_hist[frame_no] = c;
                    frame_no++;
                    gap_cnt = 0;
                end
                if (cs_n) gap_cnt++;
                chk(!(sclk && cs_n), "R1 sclk outside frame", int'(sclk), 0);
                if (smp_valid) begin
                    if (exp_ch_q.size() > 0) begin
                        chk(int'(smp_chan) == exp_ch_q[0], "R5 R6 channel", int'(smp_chan), exp_ch_q[0]);
                        chk(int'(smp_data) == exp_dat_q[0], "R6 data", int'(smp_data), exp_dat_q[0]);
                        chk(int'(smp_err) == exp_err_q[0], "R7 err flag", int'(smp_err), exp_err_q[0]);
                        void'(exp_ch_q.pop_front());
                        void'(exp_dat_q.pop_front());
                        void'(exp_err_q.pop_front());
                    end else chk(0, "R5 unexpected sample", int'(smp_chan), -1);
                end
                if (done && cur_mask != 0) begin
                    chk(exp_ch_q.size() == 0, "R8 samples left at done", exp_ch_q.size(), 0);
                    chk(smp_valid, "R8 last sample with done", int'(smp_valid), 1);
                    chk(!busy, "R8 busy at done", int'(busy), 0);
                    chk(frame_no == $countones(cur_mask) + 2, "R4 frame count",
                        frame_no, $countones(cur_mask) + 2);
                end
            end
            pcs = cs_n; psclk = sclk;
        end
    end

    task automatic run_scan(input logic [15:0] m, input int dv, input int bad_ch, input bit poke);
        scan_id++;
        cur_mask = m;
        corrupt_ch = bad_ch;
        half_div = 8'(dv);
        frame_no = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                exp_cmd_q.push_back(i);
                exp_ch_q.push_back(i);
                exp_dat_q.push_back(raw12(i) >> (12 - SB));
                exp_err_q.push_back(i == bad_ch ? 1 : 0);
            end
        end
        @(negedge clk);
        ch_mask = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (m == 0) begin
            chk(done == 1'b1, "R9 done after empty start", int'(done), 1);
            chk(busy == 1'b0, "R9 busy stays low", int'(busy), 0);
            repeat (20) @(negedge clk);
            chk(frame_no == 0, "R9 no words sent", frame_no, 0);
        end else begin
            chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
            if (poke) begin
                repeat (40) @(negedge clk);
                ch_mask = 16'h0003;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            while (!done) @(negedge clk);
            @(negedge clk);
            chk(exp_cmd_q.size() == 0, "R3 commands missing", exp_cmd_q.size(), 0);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset idle lines", int'({cs_n, sclk}), 2);
        chk(busy == 1'b0 && done == 1'b0 && smp_valid == 1'b0, "R8 reset status",
            int'({busy, done, smp_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_scan(16'h0001, 0, -1, 0);
        run_scan(16'h8000, 1, -1, 0);
        run_scan(16'hA5A5, 0, -1, 0);
        run_scan(16'hFFFF, 3, -1, 1);
        run_scan(16'h0000, 0, -1, 0);
        run_scan(16'h0410, 1, 10, 0);
        run_scan(16'h0003, 2, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule